// File: doc/BRIEF.md
# Flag-Producing Integer ALU

This block is a purely combinational integer arithmetic/logic unit for a simple datapath. It takes two operands and a six-bit control word. It returns a result and four status flags: carry, negative, zero and signed overflow.

Besides add, subtract, bitwise logic and single-bit shifts, its code space has a set of helper operations:
- pass an operand through unchanged;
- invert an operand;
- drive the constants 0, +1 and all-ones (-1).

With these, the datapath can route a register through the unit, or increment a counter, in one cycle. The carry-in is a field of the control word, not a stored flag.

The control word packs a five-bit operation code above a one-bit carry-in. Codes that are not assigned give a zero result. The block has no clock and no state. The result and flags settle within the same cycle that the operands and control are presented.

A streaming valid/ready handshake was not added. The unit sits inside a datapath cycle, not on a stream boundary, so there is no back-pressure to express.

Top module: `flag_alu`

## Requirements
- R1: Control bits [5:1] hold the operation code and bit [0] holds the carry-in. Code 00110 (add) yields A + B + cin modulo 2^W, and the carry flag is the carry out of bit W-1.
- R2: Code 00111 (subtract) yields A + ~B + 1 and ignores the carry-in. The carry flag is the carry out of that sum, so it is 1 exactly when A >= B unsigned.
- R3: Code 01010 (pass B) yields B + cin. Control word 010100 therefore passes B unchanged, and 010101 gives B + 1, with carry set when B was all ones.
- R4: Code 00011 (pass A) yields A + cin, with carry set on wrap.
- R5: Codes 00100 and 00101 yield ~A and ~B respectively, with carry and overflow cleared.
- R6: Codes 00000, 00001 and 00010 yield 0, 1 and all-ones respectively, with carry and overflow cleared.
- R7: Codes 01000, 01001 and 01011 yield A AND B, A OR B and A XOR B, with carry and overflow cleared.
- R8: Code 01100 shifts A left by one, filling bit 0 with cin; carry takes the old A[W-1]. Code 01101 shifts A right by one, filling bit W-1 with cin; carry takes the old A[0].
- R9: Code 01110 shifts A right by one while keeping its sign bit; carry takes the old A[0].
- R10: For every code, the negative flag equals result bit W-1, and the zero flag is 1 exactly when the result is all zeros.
- R11: For add, subtract, pass A and pass B, the overflow flag is 1 exactly when the two's-complement value of the operation falls outside the signed W-bit range. For all other codes it is 0.
- R12: Codes 01111 through 11111 are unused. They yield a zero result with carry, overflow and negative cleared and the zero flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | Left operand A |
| opnd_b | input | WIDTH | Right operand B |
| ctrl | input | 6 | Operation code in [5:1], carry-in in [0] |
| result | output | WIDTH | Operation result |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result is negative (bit W-1) |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Signed overflow |

## Verification
Carry and zero, or carry and overflow, can be raised by the same operation. An increment of an all-ones B gives carry and zero together. An add of two large negatives gives carry and overflow together. Subtracting equal operands gives carry with zero.

The bench provokes every such coincidence by sweeping all operand pairs, both carry-in values and all 32 codes in a 4-bit configuration. It judges all five outputs at once against an integer model that computes the unsigned sum and the signed value separately.

// File: rtl/falu_pkg.sv
package falu_pkg;

  localparam int OP_W   = 5;
  localparam int CTRL_W = OP_W + 1;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO   = 5'b00000,
    OP_ONE    = 5'b00001,
    OP_ONES   = 5'b00010,
    OP_PASS_A = 5'b00011,
    OP_NOT_A  = 5'b00100,
    OP_NOT_B  = 5'b00101,
    OP_ADD    = 5'b00110,
    OP_SUB    = 5'b00111,
    OP_AND    = 5'b01000,
    OP_OR     = 5'b01001,
    OP_PASS_B = 5'b01010,
    OP_XOR    = 5'b01011,
    OP_SHL    = 5'b01100,
    OP_SHR    = 5'b01101,
    OP_ASR    = 5'b01110
  } falu_op_e;

  localparam logic [OP_W-1:0] FIRST_UNUSED = 5'b01111;

endpackage

// File: rtl/falu_arith.sv
module falu_arith
  import falu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  falu_op_e         op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf,
  output logic             hit
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             ci;
  logic [WIDTH:0]   wide;

  // Operand steering: every adder-based code shares one carry chain.
  always_comb begin
    x   = '0;
    y   = '0;
    ci  = 1'b0;
    hit = 1'b1;
    case (op)
      OP_ADD:    begin x = a;  y = b;  ci = cin;  end
      OP_SUB:    begin x = a;  y = ~b; ci = 1'b1; end
      OP_PASS_A: begin x = a;  y = '0; ci = cin;  end
      OP_PASS_B: begin x = '0; y = b;  ci = cin;  end
      default:   hit = 1'b0;
    endcase
  end

  assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign sum  = wide[MSB:0];
  assign cout = hit & wide[WIDTH];
  assign ovf  = hit & (x[MSB] == y[MSB]) & (wide[MSB] != x[MSB]);

endmodule

// File: rtl/falu_logic.sv
module falu_logic
  import falu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  falu_op_e         op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_ZERO:  res = '0;
      OP_ONE:   res = WIDTH'(1);
      OP_ONES:  res = '1;
      OP_NOT_A: res = ~a;
      OP_NOT_B: res = ~b;
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_SHL:   begin res = {a[MSB-1:0], cin}; cout = a[MSB]; end
      OP_SHR:   begin res = {cin, a[MSB:1]};   cout = a[0];   end
      OP_ASR:   begin res = {a[MSB], a[MSB:1]}; cout = a[0];  end
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/falu_flags.sv
module falu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  output logic             neg,
  output logic             zero
);
  assign neg  = res[WIDTH-1];
  assign zero = ~|res;
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import falu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [WIDTH-1:0]  result,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v
);
  falu_op_e         op;
  logic             cin;
  logic [WIDTH-1:0] ar_sum, lg_res;
  logic             ar_c, ar_v, ar_hit, lg_c;

  assign op  = falu_op_e'(ctrl[CTRL_W-1:1]);
  assign cin = ctrl[0];

  falu_arith #(.WIDTH(WIDTH)) arith_i (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cin),
    .sum(ar_sum), .cout(ar_c), .ovf(ar_v), .hit(ar_hit)
  );

  falu_logic #(.WIDTH(WIDTH)) logic_i (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cin),
    .res(lg_res), .cout(lg_c)
  );

  assign result = ar_hit ? ar_sum : lg_res;
  assign flag_c = ar_hit ? ar_c : lg_c;
  assign flag_v = ar_hit & ar_v;

  falu_flags #(.WIDTH(WIDTH)) flags_i (
    .res(result), .neg(flag_n), .zero(flag_z)
  );

  always_comb begin
    if (ctrl[CTRL_W-1:1] == OP_ONE) begin
      // R6
      const_one_chk: assert (result == WIDTH'(1) && !flag_c && !flag_v);
    end
    if (ctrl[CTRL_W-1:1] == OP_PASS_B) begin
      // R3
      inc_b_chk: assert ({flag_c, result} == ({1'b0, opnd_b} + {{WIDTH{1'b0}}, cin}));
    end
    if (ctrl[CTRL_W-1:1] == OP_SUB) begin
      // R2
      sub_carry_chk: assert (flag_c == (opnd_a >= opnd_b));
    end
    if (ctrl[CTRL_W-1:1] >= FIRST_UNUSED) begin
      // R12
      unused_code_chk: assert (result == '0 && flag_z && !flag_c && !flag_v && !flag_n);
    end
    if (ctrl[CTRL_W-1:1] == OP_AND || ctrl[CTRL_W-1:1] == OP_XOR ||
        ctrl[CTRL_W-1:1] == OP_SHL || ctrl[CTRL_W-1:1] == OP_ASR) begin
      // R11
      no_overflow_chk: assert (!flag_v);
    end
  end

endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [5:0]   ctrl = '0;
  logic [W-1:0] result;
  logic         fc, fn, fz, fv;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flag_alu #(.WIDTH(W)) dut_i (
    .opnd_a(a), .opnd_b(b), .ctrl(ctrl), .result(result),
    .flag_c(fc), .flag_n(fn), .flag_z(fz), .flag_v(fv)
  );

  function automatic string req_of(int op);
    case (op)
      6: return "R1";  7: return "R2";  10: return "R3"; 3: return "R4";
      4, 5: return "R5"; 0, 1, 2: return "R6"; 8, 9, 11: return "R7";
      12, 13: return "R8"; 14: return "R9";
      default: return "R12";
    endcase
  endfunction

  // Returns {res[3:0], c, n, z, v}
  function automatic logic [7:0] model(int op, int ci, int ai, int bi);
    int sa = (ai >= 8) ? ai - 16 : ai;
    int sb = (bi >= 8) ? bi - 16 : bi;
    int s = 0, sr = 0, r = 0, c = 0, v = 0;
    case (op)
      0: r = 0;
      1: r = 1;
      2: r = 15;
      3: begin s = ai + ci; sr = sa + ci; r = s & 15; c = s >> 4; v = int'(sr > 7); end
      4: r = 15 - ai;
      5: r = 15 - bi;
      6: begin s = ai + bi + ci; sr = sa + sb + ci; r = s & 15; c = s >> 4;
               v = int'(sr > 7 || sr < -8); end
      7: begin s = ai + (15 - bi) + 1; sr = sa - sb; r = s & 15; c = s >> 4;
               v = int'(sr > 7 || sr < -8); end
      8: r = ai & bi;
      9: r = ai | bi;
      10: begin s = bi + ci; sr = sb + ci; r = s & 15; c = s >> 4; v = int'(sr > 7); end
      11: r = ai ^ bi;
      12: begin r = ((ai << 1) | ci) & 15; c = ai >> 3; end
      13: begin r = (ai >> 1) | (ci << 3); c = ai & 1; end
      14: begin r = (ai >> 1) | (ai & 8); c = ai & 1; end
      default: r = 0;
    endcase
    return {4'(r), 1'(c), 1'(r >> 3), 1'(r == 0), 1'(v)};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ctrl=%b a=%h b=%h got res/c/n/z/v=%h/%b%b%b%b expected %h/%b%b%b%b",
               req, ctrl, a, b, act[7:4], act[3], act[2], act[1], act[0],
               exp[7:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all-zero control and operands (R6 zero code, R10 zero flag)
    check("R6", {result, fc, fn, fz, fv}, 8'b0000_0010);
    check("R10", {7'd0, fz}, 8'd1);
    rst_n = 1'b1;
    // Directed corners: increment wrap (R3), equal subtract (R2), neg overflow add (R11)
    @(posedge clk); ctrl = 6'b010101; b = 4'hF;
    @(negedge clk); check("R3", {result, fc, fn, fz, fv}, 8'b0000_1010);
    @(posedge clk); ctrl = 6'b010100; b = 4'h9;
    @(negedge clk); check("R3", {result, fc, fn, fz, fv}, 8'b1001_0100);
    @(posedge clk); ctrl = 6'b001110; a = 4'h5; b = 4'h5;
    @(negedge clk); check("R2", {result, fc, fn, fz, fv}, 8'b0000_1010);
    @(posedge clk); ctrl = 6'b001100; a = 4'h8; b = 4'h8;
    @(negedge clk); check("R11", {result, fc, fn, fz, fv}, 8'b0000_1011);
    // Exhaustive sweep: R1..R12 including R10 flags and R11 overflow
    for (int op = 0; op < 32; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int ai = 0; ai < 16; ai++) begin
          for (int bi = 0; bi < 16; bi++) begin
            @(posedge clk);
            ctrl = {5'(op), 1'(ci)}; a = 4'(ai); b = 4'(bi);
            @(negedge clk);
            check(req_of(op), {result, fc, fn, fz, fv}, model(op, ci, ai, bi));
          end
        end
      end
    end
    finish_run();
  end

endmodule